// File: doc/BRIEF.md
# Power-Good Supervisor with Release Timer

This block produces the power-good pin level for a step-down regulator that also has a linear post-regulator. It takes digital flags that are already filtered, one per output, each saying whether that output is above its under-voltage limit. It also takes the enable state and a mode select. The output `pok_level` models an open-drain pin. A 0 means the pin is pulled low and power is not good. A 1 means the pin is released.

The release is slow and the pull-down is fast. The pin is released only after the monitored condition has held for a full delay of `DELAY_CYCLES` clocks. The default of 7,500,000 cycles gives 150 ms at 50 MHz. Any loss of the condition pulls the pin low on the next clock edge and clears the delay, so every recovery waits out the whole delay again.

The mode select chooses what is monitored. In one mode only the switching output is watched. In the other mode both outputs must be good. The supervisor does not depend on the switching stage running, so a thermal stop of the converter stays visible on the pin.

Top module: `pok_supervisor`

## Requirements
- R1: While `rst` is high, `pok_level` is 0 after the next clock edge and the delay count is cleared.
- R2: While `en` is 0, `pok_level` is 0 and no delay accumulates.
- R3: With `need_both` = 0, `ldo_ok` has no effect: release depends on `en` and `sw_ok` only.
- R4: With `need_both` = 1, both `sw_ok` and `ldo_ok` must be 1 for the condition to hold; `ldo_ok` = 0 keeps or pulls `pok_level` to 0.
- R5: `pok_level` rises at the clock edge where the condition has been sampled true on `DELAY_CYCLES` consecutive edges, and not earlier.
- R6: When the condition is sampled false at an edge, `pok_level` is 0 after that same edge.
- R7: A drop of the condition for a single clock clears the delay, so release needs a full `DELAY_CYCLES` of good samples after it.
- R8: Once released, `pok_level` stays 1 for as long as the condition stays true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Regulator enable state |
| sw_ok | input | 1 | Switching output above its under-voltage limit (filtered) |
| ldo_ok | input | 1 | Linear output above its under-voltage limit (filtered) |
| need_both | input | 1 | 0: watch the switching output only; 1: watch both outputs |
| pok_level | output | 1 | Pin level: 0 = pulled low (not good), 1 = released |

## Verification
The bench targets three kinds of error: an off-by-one in the release edge, a counter that keeps its value across a short dropout, and a mode select that is ignored or inverted.

- An off-by-one makes the pin rise one cycle early or late. The bench compares against a reference model on every clock, so it catches either.
- The bench drops a flag for one cycle partway through the count. A counter that only pauses would release before a fresh full delay has passed.
- The bench holds the linear flag low in both modes and flips the mode while released. A design that ignores the mode would release in dual mode, or would pull low when only the switching output is watched.

Enable and reset asserted mid-release check that the pull-down happens within one clock.

// File: rtl/pok_pkg.sv
package pok_pkg;
  typedef enum logic {
    POK_SW_ONLY    = 1'b0,
    POK_SW_AND_LDO = 1'b1
  } pok_mode_e;
endpackage

// File: rtl/pok_qualify.sv
module pok_qualify
  import pok_pkg::*;
(
  input  logic en,
  input  logic sw_ok,
  input  logic ldo_ok,
  input  logic need_both,
  output logic qual
);
  pok_mode_e mode;
  logic      ldo_term;

  assign mode = pok_mode_e'(need_both);

  always_comb begin
    case (mode)
      POK_SW_AND_LDO: ldo_term = ldo_ok;
      default:        ldo_term = 1'b1;
    endcase
  end

  assign qual = en & sw_ok & ldo_term;
endmodule

// File: rtl/pok_release_timer.sv
module pok_release_timer #(
  parameter int DELAY_CYCLES = 7_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic qual,
  output logic done
);
  localparam int CW = (DELAY_CYCLES > 2) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !qual)    cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LAST);

  // R1: reset leaves the count at zero
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> cnt == '0);
  // R7: any single-cycle loss clears the count
  p_clear_on_drop_r7: assert property (@(posedge clk) disable iff (rst)
    !qual |=> cnt == '0);
  // R5: the count advances by exactly one per good sample until it saturates
  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (qual && cnt != LAST) |=> cnt == $past(cnt) + 1'b1);
  // R8: a saturated count holds while the condition stays true
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (qual && cnt == LAST) |=> cnt == LAST);
endmodule

// File: rtl/pok_out_reg.sv
module pok_out_reg (
  input  logic clk,
  input  logic rst,
  input  logic qual,
  input  logic done,
  output logic pok_level
);
  always_ff @(posedge clk) begin
    if (rst) pok_level <= 1'b0;
    else     pok_level <= qual & done;
  end

  // R1: reset pulls the pin low
  p_reset_low_r1: assert property (@(posedge clk) rst |=> !pok_level);
  // R6: a lost condition pulls the pin low on the next edge
  p_fast_pull_r6: assert property (@(posedge clk) disable iff (rst)
    !qual |=> !pok_level);
  // R5: release only follows a completed delay
  p_release_gated_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(pok_level) |-> $past(done) && $past(qual));
endmodule

// File: rtl/pok_supervisor.sv
module pok_supervisor #(
  parameter int DELAY_CYCLES = 7_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sw_ok,
  input  logic ldo_ok,
  input  logic need_both,
  output logic pok_level
);
  logic qual;
  logic done;

  pok_qualify u_qual (
    .en        (en),
    .sw_ok     (sw_ok),
    .ldo_ok    (ldo_ok),
    .need_both (need_both),
    .qual      (qual)
  );

  pok_release_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .qual (qual),
    .done (done)
  );

  pok_out_reg u_out (
    .clk       (clk),
    .rst       (rst),
    .qual      (qual),
    .done      (done),
    .pok_level (pok_level)
  );

  // R2: enable low forces the pin low on the next edge
  p_disable_low_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pok_level);
  // R4: in dual mode a bad linear output forces the pin low
  p_dual_needs_ldo_r4: assert property (@(posedge clk) disable iff (rst)
    (need_both && !ldo_ok) |=> !pok_level);
endmodule

// File: tb/pok_supervisor_tb.sv
module pok_supervisor_tb;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, sw_ok = 1'b0, ldo_ok = 1'b0, need_both = 1'b0;
  logic pok_level;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int run = 0;
  logic exp_level = 1'b0;
  string cur_req = "R1";
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  pok_supervisor #(.DELAY_CYCLES(D)) u_dut (
    .clk(clk), .rst(rst), .en(en), .sw_ok(sw_ok),
    .ldo_ok(ldo_ok), .need_both(need_both), .pok_level(pok_level)
  );

  // Reference model: consecutive good samples, behavioural
  always @(posedge clk) begin
    bit good;
    cycles <= cycles + 1;
    good = en && sw_ok && (!need_both || ldo_ok);
    if (rst || !good) begin
      run = 0;
      exp_level = 1'b0;
    end else begin
      if (run < D) run = run + 1;
      exp_level = (run >= D);
    end
  end

  always @(negedge clk) begin
    if (cycles > 0 && !done_flag) begin
      checks++;
      if (pok_level !== exp_level) begin
        errors++;
        $display("FAIL %s: pok_level=%b expected=%b at cycle %0d",
                 cur_req, pok_level, exp_level, cycles);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_in(input logic e, input logic s, input logic l, input logic b);
    en = e; sw_ok = s; ldo_ok = l; need_both = b;
  endtask

  initial begin
    int t;
    // R1: reset with all inputs good
    cur_req = "R1";
    set_in(1, 1, 1, 0);
    step(4);
    rst = 1'b0;
    // R5, R8: release after D good samples, then stays high
    cur_req = "R5";
    step(D + 6);
    // R5: explicit release edge count from a fresh start
    set_in(0, 1, 1, 0);
    step(2);
    set_in(1, 1, 1, 0);
    t = 0;
    while (pok_level !== 1'b1 && t < 4 * D) begin
      step(1);
      t++;
    end
    checks++;
    if (t != D) begin
      errors++;
      $display("FAIL R5: release after %0d cycles expected=%0d", t, D);
    end
    cur_req = "R8";
    step(10);
    // R6, R7: one-cycle dropout while released, then full delay again
    cur_req = "R6";
    sw_ok = 1'b0;
    step(1);
    sw_ok = 1'b1;
    cur_req = "R7";
    step(D + 4);
    // R7: glitch mid-count
    set_in(0, 1, 1, 0);
    step(2);
    set_in(1, 1, 1, 0);
    step(D - 3);
    sw_ok = 1'b0;
    step(1);
    sw_ok = 1'b1;
    step(D + 3);
    // R3: linear output bad but ignored in switcher-only mode
    cur_req = "R3";
    ldo_ok = 1'b0;
    step(D + 4);
    ldo_ok = 1'b1;
    step(2);
    ldo_ok = 1'b0;
    step(3);
    // R4: switch to dual mode while linear output bad, pulls low
    cur_req = "R4";
    need_both = 1'b1;
    step(D + 5);
    ldo_ok = 1'b1;
    step(D + 3);
    ldo_ok = 1'b0;
    step(3);
    ldo_ok = 1'b1;
    step(D + 2);
    // R2: enable low while released, then stays low
    cur_req = "R2";
    en = 1'b0;
    step(D + 3);
    en = 1'b1;
    step(D + 2);
    // R1: reset while released
    cur_req = "R1";
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(D + 2);
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 20000);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: cycles=%0d expected<20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule